// File: doc/BRIEF.md
# Rename Snapshot Queue Controller

This block keeps the bookkeeping for up to four rename snapshots. Each snapshot is identified by the reorder-buffer index of the first micro-op that follows it. The rename datapath and the stored speculative tables live elsewhere. This block only decides three things and broadcasts each decision to the modules that own those tables. It decides when a snapshot is taken. It decides when the oldest snapshot is retired because commit has reached it. It decides which snapshots must be discarded because a redirect put them on the wrong path.

Each cycle the block sees one rename group of up to six micro-ops, together with a per-op branch flag and the index of the group's first op. It also sees up to eight committing indices and one redirect. The enqueue, dequeue, flush, hit and slot outputs are combinational decisions for the current cycle. Queue state changes at the next clock edge.

There is no back-pressure. A snapshot request that arrives while the queue is full is dropped, and the group still proceeds.

Top module: `snap_queue_ctrl`

A reorder-buffer index is `{wrap, pos}`. `pos` runs from 0 to ROB_ENTRIES-1, and `wrap` toggles every time `pos` wraps. Index `a` is newer than index `b` in either of two cases:
- the wrap bits are equal and `a.pos > b.pos`;
- the wrap bits differ and `a.pos < b.pos`.

## Requirements
- R1: After reset all four slots are empty, `enq_ptr` and `deq_ptr` are 0, and `snap_enq`, `snap_deq`, `flush_vec` and `hit_valid` are 0.
- R2: A group with at least one valid op requests a snapshot in either of two cases: some valid op has its branch flag set, or the ops counted since the last snapshot plus this group's valid ops reach 32. The snapshot records `ren_first_idx`, because the request of every op in the group is folded onto the first op.
- R3: The op counter clears in any cycle where `snap_enq` is high. In a redirect cycle it holds. Otherwise it adds the group's valid ops, saturating at 32.
- R4: `snap_enq` is high only when there is a request, the slot at `enq_ptr` is empty and no redirect is present. On the next edge that slot becomes valid with the recorded index, and `enq_ptr` advances by one modulo 4.
- R5: When all four slots are valid, a request is dropped (`snap_enq` stays 0) and the state is unchanged.
- R6: `snap_deq` is high when the slot at `deq_ptr` is valid, some valid commit lane carries exactly the index stored in that slot, and no redirect is present. On the next edge the slot empties and `deq_ptr` advances by one.
- R7: During a redirect, `flush_vec[i]` is 1 exactly for the valid slots whose index is strictly newer than `redir_idx` under the wrap rule. Those slots are empty after the next edge.
- R8: After a non-zero flush vector, `enq_ptr` becomes the first empty slot found by scanning forward from `deq_ptr`.
- R9: During a redirect, a valid slot qualifies for recovery if its index is older than `redir_idx`, or equal to it when `redir_self` is 1. `hit_valid` is 1 if any slot qualifies, and `hit_slot` names the youngest qualifying slot. Without a hit, `hit_slot` is 0.
- R10: Without a redirect, `flush_vec` is 0, `hit_valid` is 0 and `hit_slot` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | RENAME_W | Valid flag of each op in the rename group |
| ren_branch | input | RENAME_W | Branch/jump flag of each op |
| ren_first_idx | input | IDX_W | Reorder-buffer index of the group's first op |
| cmt_valid | input | COMMIT_W | Valid flag of each commit lane |
| cmt_idx | input | COMMIT_W x IDX_W | Index committed on each lane |
| redir_valid | input | 1 | Redirect present this cycle |
| redir_idx | input | IDX_W | Index of the redirecting op |
| redir_self | input | 1 | The redirecting op itself is flushed |
| snap_enq | output | 1 | Take a snapshot this cycle |
| snap_deq | output | 1 | Retire the snapshot at `deq_ptr` this cycle |
| flush_vec | output | SNAP_NUM | Slots discarded by this redirect |
| hit_valid | output | 1 | A recovery snapshot exists |
| hit_slot | output | SLOT_W | Slot used for recovery |
| enq_ptr | output | SLOT_W | Next slot to be written |
| deq_ptr | output | SLOT_W | Oldest slot |

## Verification
The bench drives long runs of ops through the reorder-buffer index space so that the stored indices wrap many times. Under wrap, a plain magnitude comparison would flush old snapshots and keep young ones. The bench fills all four slots and then sends one more branch, catching a design that overwrites the oldest snapshot. It issues redirects that exactly match a stored index, both with and without the self-flush flag, and a redirect that partially flushes a full queue. This exposes an off-by-one in hit selection, and also an enqueue pointer that is left pointing at a valid slot after the flush. A commit that matches in the same cycle as a redirect checks that a design does not retire a snapshot on the redirect's cycle.

// File: rtl/snapq_pkg.sv
package snapq_pkg;

  localparam int unsigned SNAP_NUM_DEF    = 4;
  localparam int unsigned ROB_ENTRIES_DEF = 160;
  localparam int unsigned RENAME_W_DEF    = 6;
  localparam int unsigned COMMIT_W_DEF    = 8;
  localparam int unsigned PERIOD_DEF      = 32;

  // Age order of two wrapped reorder-buffer indices: 1 when a is newer than b.
  function automatic logic idx_newer(input logic a_wrap, input logic [31:0] a_pos,
                                     input logic b_wrap, input logic [31:0] b_pos);
    if (a_wrap == b_wrap) return a_pos > b_pos;
    else                  return a_pos < b_pos;
  endfunction

endpackage

// File: rtl/snapq_trigger.sv
module snapq_trigger #(
  parameter int unsigned RENAME_W = 6,
  parameter int unsigned PERIOD   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RENAME_W-1:0] ren_valid,
  input  logic [RENAME_W-1:0] ren_branch,
  input  logic                redir_valid,
  input  logic                take,
  output logic                req
);
  localparam int unsigned CNT_W = $clog2(PERIOD + 1);
  localparam int unsigned SUM_W = $clog2(PERIOD + RENAME_W + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SUM_W-1:0] sum;
  logic             any_op, any_br, reach;

  always_comb begin
    sum = SUM_W'(cnt_q);
    for (int i = 0; i < RENAME_W; i++) sum = sum + SUM_W'(ren_valid[i]);
    any_op = |ren_valid;
    any_br = |(ren_valid & ren_branch);
    reach  = sum >= SUM_W'(PERIOD);
    req    = any_op && (any_br || reach);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (take)             cnt_d = '0;
    else if (redir_valid) cnt_d = cnt_q;
    else if (any_op)      cnt_d = reach ? CNT_W'(PERIOD) : CNT_W'(sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(PERIOD)); // R3
  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> cnt_q == '0); // R3

endmodule

// File: rtl/snapq_store.sv
module snapq_store #(
  parameter int unsigned N      = 4,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned SLOT_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enq,
  input  logic [IDX_W-1:0]          enq_idx,
  input  logic                      deq,
  input  logic [N-1:0]              flush,
  output logic [N-1:0]              slot_vld,
  output logic [N-1:0][IDX_W-1:0]   slot_idx,
  output logic [SLOT_W-1:0]         enq_ptr,
  output logic [SLOT_W-1:0]         deq_ptr,
  output logic                      full
);
  logic [SLOT_W-1:0] enq_nxt, scan_s;
  logic              found;

  assign full = slot_vld[enq_ptr];

  // After a flush the write slot restarts at the first hole seen from the oldest slot.
  always_comb begin
    enq_nxt = enq_ptr + SLOT_W'(enq);
    found   = 1'b0;
    scan_s  = deq_ptr;
    if (|flush) begin
      enq_nxt = deq_ptr;
      for (int k = 0; k < N; k++) begin
        scan_s = deq_ptr + SLOT_W'(k);
        if (!found && !(slot_vld[scan_s] && !flush[scan_s])) begin
          enq_nxt = scan_s;
          found   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_vld <= '0;
      slot_idx <= '0;
      enq_ptr  <= '0;
      deq_ptr  <= '0;
    end else begin
      for (int i = 0; i < N; i++)
        if (flush[i]) slot_vld[i] <= 1'b0;
      if (enq) begin
        slot_vld[enq_ptr] <= 1'b1;
        slot_idx[enq_ptr] <= enq_idx;
      end
      if (deq) begin
        slot_vld[deq_ptr] <= 1'b0;
        deq_ptr           <= deq_ptr + 1'b1;
      end
      enq_ptr <= enq_nxt;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    enq |-> !slot_vld[enq_ptr]); // R5
  AST_DEQ_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    deq |-> slot_vld[deq_ptr]); // R6
  AST_ENQ_HOLE_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (|flush) |=> !slot_vld[enq_ptr]); // R8

  for (genvar g = 0; g < N; g++) begin : g_flush_chk
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush[g] |=> !slot_vld[g]); // R7
  end

endmodule

// File: rtl/snapq_match.sv
module snapq_match
  import snapq_pkg::*;
#(
  parameter int unsigned N        = 4,
  parameter int unsigned IDX_W    = 9,
  parameter int unsigned SLOT_W   = 2,
  parameter int unsigned COMMIT_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N-1:0]                 slot_vld,
  input  logic [N-1:0][IDX_W-1:0]      slot_idx,
  input  logic [SLOT_W-1:0]            deq_ptr,
  input  logic [COMMIT_W-1:0]          cmt_valid,
  input  logic [COMMIT_W-1:0][IDX_W-1:0] cmt_idx,
  input  logic                         redir_valid,
  input  logic [IDX_W-1:0]             redir_idx,
  input  logic                         redir_self,
  output logic                         deq_hit,
  output logic [N-1:0]                 flush_vec,
  output logic                         hit_valid,
  output logic [SLOT_W-1:0]            hit_slot
);
  localparam int unsigned POS_W = IDX_W - 1;

  logic [N-1:0]      usable;
  logic              any_use;
  logic [SLOT_W-1:0] pick, s;

  always_comb begin
    deq_hit = 1'b0;
    for (int c = 0; c < COMMIT_W; c++)
      if (cmt_valid[c] && cmt_idx[c] == slot_idx[deq_ptr]) deq_hit = 1'b1;
    deq_hit = deq_hit && slot_vld[deq_ptr];
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      flush_vec[i] = redir_valid && slot_vld[i] &&
        idx_newer(slot_idx[i][IDX_W-1], 32'(slot_idx[i][POS_W-1:0]),
                  redir_idx[IDX_W-1], 32'(redir_idx[POS_W-1:0]));
      usable[i] = slot_vld[i] &&
        (idx_newer(redir_idx[IDX_W-1], 32'(redir_idx[POS_W-1:0]),
                   slot_idx[i][IDX_W-1], 32'(slot_idx[i][POS_W-1:0])) ||
         (redir_self && slot_idx[i] == redir_idx));
    end
  end

  // Valid slots run oldest to youngest from deq_ptr, so the last usable one is the youngest.
  always_comb begin
    any_use = 1'b0;
    pick    = '0;
    s       = deq_ptr;
    for (int k = 0; k < N; k++) begin
      s = deq_ptr + SLOT_W'(k);
      if (usable[s]) begin
        any_use = 1'b1;
        pick    = s;
      end
    end
    hit_valid = redir_valid && any_use;
    hit_slot  = hit_valid ? pick : '0;
  end

  AST_HIT_NOT_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> (slot_vld[hit_slot] && !flush_vec[hit_slot])); // R9
  AST_QUIET_NO_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_valid |-> (flush_vec == '0 && !hit_valid)); // R10

endmodule

// File: rtl/snap_queue_ctrl.sv
module snap_queue_ctrl
  import snapq_pkg::*;
#(
  parameter int unsigned SNAP_NUM    = SNAP_NUM_DEF,
  parameter int unsigned ROB_ENTRIES = ROB_ENTRIES_DEF,
  parameter int unsigned RENAME_W    = RENAME_W_DEF,
  parameter int unsigned COMMIT_W    = COMMIT_W_DEF,
  parameter int unsigned PERIOD      = PERIOD_DEF,
  parameter int unsigned IDX_W       = $clog2(ROB_ENTRIES) + 1,
  parameter int unsigned SLOT_W      = $clog2(SNAP_NUM)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [RENAME_W-1:0]            ren_valid,
  input  logic [RENAME_W-1:0]            ren_branch,
  input  logic [IDX_W-1:0]               ren_first_idx,
  input  logic [COMMIT_W-1:0]            cmt_valid,
  input  logic [COMMIT_W-1:0][IDX_W-1:0] cmt_idx,
  input  logic                           redir_valid,
  input  logic [IDX_W-1:0]               redir_idx,
  input  logic                           redir_self,
  output logic                           snap_enq,
  output logic                           snap_deq,
  output logic [SNAP_NUM-1:0]            flush_vec,
  output logic                           hit_valid,
  output logic [SLOT_W-1:0]              hit_slot,
  output logic [SLOT_W-1:0]              enq_ptr,
  output logic [SLOT_W-1:0]              deq_ptr
);
  logic                               req, full, deq_hit;
  logic [SNAP_NUM-1:0]                slot_vld;
  logic [SNAP_NUM-1:0][IDX_W-1:0]     slot_idx;

  assign snap_enq = req && !full && !redir_valid;
  assign snap_deq = deq_hit && !redir_valid;

  snapq_trigger #(.RENAME_W(RENAME_W), .PERIOD(PERIOD)) u_trig (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_branch(ren_branch),
    .redir_valid(redir_valid), .take(snap_enq), .req(req)
  );

  snapq_store #(.N(SNAP_NUM), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .enq(snap_enq), .enq_idx(ren_first_idx),
    .deq(snap_deq), .flush(flush_vec), .slot_vld(slot_vld), .slot_idx(slot_idx),
    .enq_ptr(enq_ptr), .deq_ptr(deq_ptr), .full(full)
  );

  snapq_match #(.N(SNAP_NUM), .IDX_W(IDX_W), .SLOT_W(SLOT_W), .COMMIT_W(COMMIT_W)) u_match (
    .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_idx(slot_idx),
    .deq_ptr(deq_ptr), .cmt_valid(cmt_valid), .cmt_idx(cmt_idx),
    .redir_valid(redir_valid), .redir_idx(redir_idx), .redir_self(redir_self),
    .deq_hit(deq_hit), .flush_vec(flush_vec), .hit_valid(hit_valid), .hit_slot(hit_slot)
  );

  AST_REDIR_BLOCKS_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> ($stable(deq_ptr))); // R6

endmodule

// File: tb/snap_queue_ctrl_test.sv
`timescale 1ns/1ps
module snap_queue_ctrl_test;
  localparam int ROBN = 160;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] ren_valid = '0, ren_branch = '0;
  logic [8:0] ren_first_idx = '0;
  logic [7:0] cmt_valid = '0;
  logic [7:0][8:0] cmt_idx = '0;
  logic redir_valid = 1'b0, redir_self = 1'b0;
  logic [8:0] redir_idx = '0;
  logic snap_enq, snap_deq, hit_valid;
  logic [3:0] flush_vec;
  logic [1:0] hit_slot, enq_ptr, deq_ptr;

  always #10 clk = ~clk;

  snap_queue_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_branch(ren_branch),
    .ren_first_idx(ren_first_idx), .cmt_valid(cmt_valid), .cmt_idx(cmt_idx),
    .redir_valid(redir_valid), .redir_idx(redir_idx), .redir_self(redir_self),
    .snap_enq(snap_enq), .snap_deq(snap_deq), .flush_vec(flush_vec),
    .hit_valid(hit_valid), .hit_slot(hit_slot), .enq_ptr(enq_ptr), .deq_ptr(deq_ptr)
  );

  int checks = 0, errors = 0;
  int m_lin[4];
  bit m_v[4];
  int m_enq, m_deq, m_cnt, lin_alloc, lin_cmt;

  // op[15:14]: 0 group (valid [11:6], branch [5:0]), 1 commit (count [3:0]),
  // 2 redirect (self [12], distance back from newest op [7:0]), 3 idle
  localparam logic [15:0] VEC [17] = '{
    {2'd0, 2'b0, 6'h3F, 6'h01}, {2'd0, 2'b0, 6'h3F, 6'h00}, {2'd0, 2'b0, 6'h3F, 6'h00},
    {2'd0, 2'b0, 6'h3F, 6'h00}, {2'd0, 2'b0, 6'h3F, 6'h00}, {2'd0, 2'b0, 6'h3F, 6'h00},
    {2'd0, 2'b0, 6'h3F, 6'h00}, {2'd0, 2'b0, 6'h3F, 6'h20}, {2'd0, 2'b0, 6'h01, 6'h01},
    {2'd0, 2'b0, 6'h3F, 6'h01}, {2'd1, 14'd8},              {2'd2, 1'b0, 1'b0, 4'd0, 8'd10},
    {2'd2, 1'b0, 1'b1, 4'd0, 8'd0}, {2'd0, 2'b0, 6'h3F, 6'h01}, {2'd2, 1'b0, 1'b1, 4'd0, 8'd8},
    {2'd2, 1'b0, 1'b0, 4'd0, 8'd0}, {2'd3, 14'd0}
  };

  function automatic logic [8:0] to_idx(input int lin);
    return {1'((lin / ROBN) % 2), 8'(lin % ROBN)};
  endfunction

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_v[i] = 0; m_lin[i] = 0; end
    m_enq = 0; m_deq = 0; m_cnt = 0; lin_alloc = 0; lin_cmt = 0;
  endtask

  // Commit count limited to in-flight ops and to stop before the second-oldest snapshot.
  function automatic int clamp_cmt(input int n);
    int lim = lin_alloc - lin_cmt;
    int nx = (m_deq + 1) % 4;
    if (m_v[nx] && m_lin[nx] - lin_cmt < lim) lim = m_lin[nx] - lin_cmt;
    if (n > lim) n = lim;
    if (n > 8) n = 8;
    return n;
  endfunction

  task automatic step(input logic [5:0] gv, input logic [5:0] gb, input int ncmt,
                      input bit rd, input int rlin, input bit rs);
    int pop = 0, es = 0, s;
    bit req, e_enq, e_deq, eh = 0;
    bit [3:0] e_fl;
    @(negedge clk);
    ren_valid = gv; ren_branch = gb; ren_first_idx = to_idx(lin_alloc);
    for (int k = 0; k < 8; k++) begin
      cmt_valid[k] = (k < ncmt);
      cmt_idx[k] = to_idx(lin_cmt + k);
    end
    redir_valid = rd; redir_idx = to_idx(rlin); redir_self = rs;
    for (int i = 0; i < 6; i++) pop += int'(gv[i]);
    req = (gv != 0) && (((gv & gb) != 0) || (m_cnt + pop >= 32));
    e_enq = req && !m_v[m_enq] && !rd;
    e_deq = !rd && m_v[m_deq] && m_lin[m_deq] >= lin_cmt && m_lin[m_deq] < lin_cmt + ncmt;
    for (int i = 0; i < 4; i++) e_fl[i] = rd && m_v[i] && (m_lin[i] > rlin);
    for (int k = 0; k < 4; k++) begin
      s = (m_deq + k) % 4;
      if (rd && m_v[s] && (m_lin[s] < rlin || (rs && m_lin[s] == rlin))) begin
        eh = 1; es = s;
      end
    end
    #2;
    check("R2/R4/R5 snap_enq", int'(snap_enq), int'(e_enq));
    check("R6 snap_deq", int'(snap_deq), int'(e_deq));
    check("R7/R10 flush_vec", int'(flush_vec), int'(e_fl));
    check("R9/R10 hit_valid", int'(hit_valid), int'(eh));
    check("R9 hit_slot", int'(hit_slot), es);
    check("R4/R8 enq_ptr", int'(enq_ptr), m_enq);
    check("R6 deq_ptr", int'(deq_ptr), m_deq);
    if (e_enq) begin m_v[m_enq] = 1; m_lin[m_enq] = lin_alloc; m_enq = (m_enq + 1) % 4; end
    if (e_deq) begin m_v[m_deq] = 0; m_deq = (m_deq + 1) % 4; end
    if (e_fl != 0) begin
      bit got = 0;
      for (int i = 0; i < 4; i++) if (e_fl[i]) m_v[i] = 0;
      for (int k = 0; k < 4; k++) begin
        s = (m_deq + k) % 4;
        if (!got && !m_v[s]) begin m_enq = s; got = 1; end
      end
    end
    if (e_enq) m_cnt = 0;
    else if (!rd && gv != 0) m_cnt = (m_cnt + pop >= 32) ? 32 : m_cnt + pop;
    lin_alloc += pop;
    lin_cmt += ncmt;
    if (rd) lin_alloc = rs ? rlin : rlin + 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ren_valid = '0; ren_branch = '0; cmt_valid = '0; redir_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    #2;
    check("R1 enq_ptr", int'(enq_ptr), 0);
    check("R1 deq_ptr", int'(deq_ptr), 0);
    check("R1 snap_enq", int'(snap_enq), 0);
    check("R1 snap_deq", int'(snap_deq), 0);
    check("R1 flush_vec", int'(flush_vec), 0);
    check("R1 hit_valid", int'(hit_valid), 0);
  endtask

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rl;
    model_reset();
    do_reset();
    for (int i = 0; i < 17; i++) begin
      case (VEC[i][15:14])
        2'd0: step(VEC[i][11:6], VEC[i][5:0], 0, 0, 0, 0);
        2'd1: step('0, '0, clamp_cmt(int'(VEC[i][3:0])), 0, 0, 0);
        2'd2: begin
          rl = lin_alloc - 1 - int'(VEC[i][7:0]);
          if (rl < lin_cmt) rl = lin_cmt;
          step('0, '0, 0, 1, rl, VEC[i][12]);
        end
        default: step('0, '0, 0, 0, 0, 0);
      endcase
    end
    for (int c = 0; c < 4000; c++) begin
      int r = int'($urandom % 100);
      logic [5:0] gv = '0, gb = '0;
      if (r < 8 && lin_alloc > lin_cmt) begin
        rl = lin_cmt + int'($urandom % 32'(lin_alloc - lin_cmt));
        step('0, '0, 0, 1, rl, 1'($urandom));
      end else begin
        if (lin_alloc - lin_cmt < 150 && r < 70) begin
          gv = 6'($urandom);
          gb = 6'($urandom & $urandom & $urandom);
        end
        step(gv, gb, clamp_cmt(int'($urandom % 9)), 0, 0, 0);
      end
    end
    // R6: a matching commit in a redirect cycle must not retire the snapshot
    do_reset();
    step(6'h3F, 6'h01, 0, 0, 0, 0);
    step('0, '0, 1, 1, 3, 0);
    step('0, '0, 0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule